// File: doc/BRIEF.md
# Per-CPU Device Interrupt Mask Router

This block steers a shared set of level-sensitive device interrupt request lines to a small group of processors. Every clock it samples the request lines into a raw request vector. Each processor has its own mask register. ANDing that mask with the raw vector gives the processor's routed vector, and the block raises the processor's interrupt line while the routed vector holds any set bit. Software sets, changes and clears masks to decide which processor services which device. The routed vectors and the raw vector can be read back for diagnosis.

Registers are reached through a simple register bus. A request is presented for one cycle. A response arrives on the next cycle, with read data and an error flag. The register index is the byte address shifted right by 6, so registers sit 64 bytes apart and the low six address bits are not decoded. With the default four processors, indices 0 to 3 are the mask registers (read/write), indices 4 to 7 are the routed vectors (read-only) and index 8 is the raw vector (read-only). In general, masks occupy 0..N-1, routed vectors occupy N..2N-1 and the raw vector sits at 2N.

Top module: `dev_irq_router`

## Requirements
- R1: After a synchronous active-low reset, every mask, routed vector, sampled raw value, interrupt output, response valid and error flag is zero.
- R2: A full-width write (size code 3, meaning 8 bytes) to index c, where c is below the processor count, replaces processor c's mask. A full-width read of that index returns the mask on the following cycle without an error.
- R3: The routed vector of processor c equals its mask ANDed with the sampled raw vector. It can be read at index N+c.
- R4: The raw vector is the request lines sampled once per clock. A full-width read of index 2N returns it.
- R5: Processor c's interrupt output is the OR of its routed vector, registered. After a mask write that routes an active request, the output rises on the second clock edge after the edge that accepts the write.
- R6: A mask write that removes the last routed bit of a processor lowers that processor's interrupt output, with the same two-edge latency.
- R7: Any access whose size code is not 3 (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes) raises the error flag in its response cycle, returns zero read data and changes no register.
- R8: A write to a routed-vector index or to the raw index raises the error flag and changes no value the block holds.
- R9: An access to an index above 2N returns zero read data. The error flag is high for exactly that one response cycle.
- R10: Every request produces exactly one response-valid pulse, on the cycle after the request. There is no response when there is no request.
- R11: Each processor's interrupt output depends only on its own mask. Writing one processor's mask never changes another processor's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid_i | input | 1 | Register request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Access size as log2 of bytes; 3 is the only legal value |
| req_addr_i | input | ADDR_W (12) | Byte offset from block base |
| req_wdata_i | input | VEC_W (64) | Write data |
| dev_req_i | input | VEC_W (64) | Level-sensitive device request lines |
| rsp_valid_o | output | 1 | Response for the previous cycle's request |
| rsp_rdata_o | output | VEC_W (64) | Read data; zero for writes and failed accesses |
| err_o | output | 1 | Error flag of the current response |
| irq_o | output | NUM_CPU (4) | Device interrupt level per processor |

## Verification
A mask write and a change of the device request lines can land in the same clock edge. The routed vector must then combine the new mask with the newly sampled raw value, and neither update may be lost. The random phase provokes this by driving a fresh request pattern on the same cycle that it writes a random mask to a random processor. After the pipeline settles, the bench reads back the routed and raw vectors and compares every interrupt line against a model built from the last written masks and the last driven request pattern. Directed cases separately pin the two-edge interrupt latency and the error responses.

// File: rtl/dmr_pkg.sv
// Package: shared encodings for the device interrupt mask router.
// Assumes the register index is the byte address shifted right by STRIDE_SHIFT.
package dmr_pkg;
    typedef enum logic [1:0] {
        RGN_MASK   = 2'd0,
        RGN_ROUTED = 2'd1,
        RGN_RAW    = 2'd2,
        RGN_NONE   = 2'd3
    } region_e;

    localparam logic [1:0] SIZE_FULL    = 2'd3;
    localparam int         STRIDE_SHIFT = 6;
endpackage

// File: rtl/dmr_decode.sv
// Module: dmr_decode
// Maps a register index onto a region and a processor select.
// Assumes NUM_CPU >= 2. Masks occupy [0,N), routed vectors [N,2N), raw at 2N.
module dmr_decode #(
    parameter int NUM_CPU = 4,
    parameter int IDX_W   = 6
) (
    input  logic [IDX_W-1:0]           idx_i,
    output dmr_pkg::region_e           region_o,
    output logic [$clog2(NUM_CPU)-1:0] sel_o
);
    localparam int CPU_W = $clog2(NUM_CPU);
    localparam logic [IDX_W-1:0] N_IDX   = IDX_W'(NUM_CPU);
    localparam logic [IDX_W-1:0] RAW_IDX = IDX_W'(2 * NUM_CPU);

    logic [IDX_W-1:0] off;

    // Classify the index and derive the processor number within its region.
    always_comb begin
        off = idx_i - N_IDX;
        if (idx_i < N_IDX) begin
            region_o = dmr_pkg::RGN_MASK;
            sel_o    = idx_i[CPU_W-1:0];
        end else if (idx_i < RAW_IDX) begin
            region_o = dmr_pkg::RGN_ROUTED;
            sel_o    = off[CPU_W-1:0];
        end else if (idx_i == RAW_IDX) begin
            region_o = dmr_pkg::RGN_RAW;
            sel_o    = '0;
        end else begin
            region_o = dmr_pkg::RGN_NONE;
            sel_o    = '0;
        end
    end
endmodule

// File: rtl/dmr_regs.sv
// Module: dmr_regs
// Holds the per-processor mask registers and serves the register bus.
// Responses are registered one cycle after the request; illegal accesses
// (narrow size, unmapped index, write to read-only) raise err and change nothing.
module dmr_regs #(
    parameter int NUM_CPU = 4,
    parameter int VEC_W   = 64,
    parameter int IDX_W   = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid_i,
    input  logic                           req_write_i,
    input  logic [1:0]                     req_size_i,
    input  logic [IDX_W-1:0]               req_idx_i,
    input  logic [VEC_W-1:0]               req_wdata_i,
    input  logic [NUM_CPU-1:0][VEC_W-1:0]  routed_i,
    input  logic [VEC_W-1:0]               raw_i,
    output logic [NUM_CPU-1:0][VEC_W-1:0]  mask_o,
    output logic                           rsp_valid_o,
    output logic [VEC_W-1:0]               rsp_rdata_o,
    output logic                           err_o
);
    localparam int CPU_W = $clog2(NUM_CPU);

    dmr_pkg::region_e   region;
    logic [CPU_W-1:0]   sel;
    logic               full;
    logic               bad;
    logic               wr_mask;
    logic [VEC_W-1:0]   rd_sel;
    logic [VEC_W-1:0]   rd_next;

    dmr_decode #(.NUM_CPU(NUM_CPU), .IDX_W(IDX_W)) u_dec (
        .idx_i    (req_idx_i),
        .region_o (region),
        .sel_o    (sel)
    );

    // Judge legality of the request and pick the read source.
    always_comb begin
        full    = (req_size_i == dmr_pkg::SIZE_FULL);
        bad     = !full || (region == dmr_pkg::RGN_NONE) ||
                  (req_write_i && (region != dmr_pkg::RGN_MASK));
        wr_mask = req_valid_i && req_write_i && !bad;
        unique case (region)
            dmr_pkg::RGN_MASK:   rd_sel = mask_o[sel];
            dmr_pkg::RGN_ROUTED: rd_sel = routed_i[sel];
            dmr_pkg::RGN_RAW:    rd_sel = raw_i;
            default:             rd_sel = '0;
        endcase
        rd_next = (req_valid_i && !req_write_i && !bad) ? rd_sel : '0;
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_mask
        // Replace this processor's mask on a legal write aimed at it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_o[c] <= '0;
            else if (wr_mask && (sel == CPU_W'(c)))
                mask_o[c] <= req_wdata_i;
        end
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_rdata_o <= '0;
            err_o       <= 1'b0;
        end else begin
            rsp_valid_o <= req_valid_i;
            rsp_rdata_o <= rd_next;
            err_o       <= req_valid_i && bad;
        end
    end
endmodule

// File: rtl/dmr_route.sv
// Module: dmr_route
// Samples the device request lines, forms each processor's routed vector
// (mask AND raw) every cycle, and registers the OR of it as an interrupt level.
module dmr_route #(
    parameter int NUM_CPU = 4,
    parameter int VEC_W   = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [VEC_W-1:0]               dev_req_i,
    input  logic [NUM_CPU-1:0][VEC_W-1:0]  mask_i,
    output logic [VEC_W-1:0]               raw_o,
    output logic [NUM_CPU-1:0][VEC_W-1:0]  routed_o,
    output logic [NUM_CPU-1:0]             irq_o
);
    // Sample the request lines once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_o <= '0;
        else        raw_o <= dev_req_i;
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        // Recompute the routed vector and its interrupt level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                routed_o[c] <= '0;
                irq_o[c]    <= 1'b0;
            end else begin
                routed_o[c] <= mask_i[c] & raw_o;
                irq_o[c]    <= |routed_o[c];
            end
        end
    end
endmodule

// File: rtl/dev_irq_router.sv
// Module: dev_irq_router (top)
// Per-processor device interrupt masking router. Assumes a single clock,
// synchronous active-low reset, and that only full-width accesses are legal.
module dev_irq_router #(
    parameter int NUM_CPU = 4,
    parameter int VEC_W   = 64,
    parameter int ADDR_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid_i,
    input  logic                 req_write_i,
    input  logic [1:0]           req_size_i,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  logic [VEC_W-1:0]     req_wdata_i,
    input  logic [VEC_W-1:0]     dev_req_i,
    output logic                 rsp_valid_o,
    output logic [VEC_W-1:0]     rsp_rdata_o,
    output logic                 err_o,
    output logic [NUM_CPU-1:0]   irq_o
);
    localparam int IDX_W = ADDR_W - dmr_pkg::STRIDE_SHIFT;

    logic [NUM_CPU-1:0][VEC_W-1:0] mask;
    logic [NUM_CPU-1:0][VEC_W-1:0] routed;
    logic [VEC_W-1:0]              raw;

    dmr_regs #(.NUM_CPU(NUM_CPU), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_size_i  (req_size_i),
        .req_idx_i   (req_addr_i[ADDR_W-1:dmr_pkg::STRIDE_SHIFT]),
        .req_wdata_i (req_wdata_i),
        .routed_i    (routed),
        .raw_i       (raw),
        .mask_o      (mask),
        .rsp_valid_o (rsp_valid_o),
        .rsp_rdata_o (rsp_rdata_o),
        .err_o       (err_o)
    );

    dmr_route #(.NUM_CPU(NUM_CPU), .VEC_W(VEC_W)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_req_i (dev_req_i),
        .mask_i    (mask),
        .raw_o     (raw),
        .routed_o  (routed),
        .irq_o     (irq_o)
    );
endmodule

// File: rtl/dev_irq_router_chk.sv
// Module: dev_irq_router_chk
// Port-level protocol checks for dev_irq_router, attached with bind.
module dev_irq_router_chk #(
    parameter int NUM_CPU = 4,
    parameter int VEC_W   = 64,
    parameter int ADDR_W  = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid_i,
    input logic               req_write_i,
    input logic [1:0]         req_size_i,
    input logic [ADDR_W-1:0]  req_addr_i,
    input logic               rsp_valid_o,
    input logic [VEC_W-1:0]   rsp_rdata_o,
    input logic               err_o
);
    localparam int IDX_W = ADDR_W - 6;
    localparam logic [IDX_W-1:0] N_IDX   = IDX_W'(NUM_CPU);
    localparam logic [IDX_W-1:0] RAW_IDX = IDX_W'(2 * NUM_CPU);

    logic [IDX_W-1:0] idx;
    assign idx = req_addr_i[ADDR_W-1:6];

    a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !rsp_valid_o);
    a_r7_narrow_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_size_i != 2'd3) |=> (err_o && rsp_rdata_o == '0));
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && idx > RAW_IDX) |=> (err_o && rsp_rdata_o == '0));
    a_r8_ro_write_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_write_i && idx >= N_IDX && idx <= RAW_IDX) |=> err_o);
    a_r2_mask_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_size_i == 2'd3 && idx < N_IDX) |=> !err_o);
    a_r9_err_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> rsp_valid_o);
endmodule

bind dev_irq_router dev_irq_router_chk #(
    .NUM_CPU (NUM_CPU),
    .VEC_W   (VEC_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_size_i  (req_size_i),
    .req_addr_i  (req_addr_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .err_o       (err_o)
);

// File: tb/tb_dev_irq_router.sv
module tb_dev_irq_router;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 4;
    localparam int W    = 64;
    localparam int AW   = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid_i = 1'b0;
    logic            req_write_i = 1'b0;
    logic [1:0]      req_size_i = 2'd3;
    logic [AW-1:0]   req_addr_i = '0;
    logic [W-1:0]    req_wdata_i = '0;
    logic [W-1:0]    dev_req_i = '0;
    logic            rsp_valid_o;
    logic [W-1:0]    rsp_rdata_o;
    logic            err_o;
    logic [NCPU-1:0] irq_o;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] m_mask [NCPU];
    logic [W-1:0] m_raw;
    logic         last_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    dev_irq_router #(.NUM_CPU(NCPU), .VEC_W(W), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i),
        .req_size_i(req_size_i), .req_addr_i(req_addr_i),
        .req_wdata_i(req_wdata_i), .dev_req_i(dev_req_i),
        .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
        .err_o(err_o), .irq_o(irq_o)
    );

    function automatic logic [W-1:0] exp_routed(int c);
        return m_mask[c] & m_raw;
    endfunction

    function automatic logic [NCPU-1:0] exp_irq();
        logic [NCPU-1:0] v;
        for (int c = 0; c < NCPU; c++) v[c] = |(m_mask[c] & m_raw);
        return v;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Issue one access at a negedge; returns after the response is visible.
    task automatic access(bit wr, int idx, logic [W-1:0] data, logic [1:0] sz,
                          logic [W-1:0] raw, output logic [W-1:0] rd);
        req_valid_i = 1'b1;
        req_write_i = wr;
        req_addr_i  = AW'(idx << 6);
        req_wdata_i = data;
        req_size_i  = sz;
        dev_req_i   = raw;
        @(negedge clk);
        req_valid_i = 1'b0;
        rd = rsp_rdata_o;
        last_err = err_o;
        check("R10 rsp_valid", W'(rsp_valid_o), W'(1));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [W-1:0] rd;
        void'($urandom(32'd20240611));
        for (int c = 0; c < NCPU; c++) m_mask[c] = '0;
        m_raw = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 irq", W'(irq_o), '0);
        check("R1 rsp_valid", W'(rsp_valid_o), '0);
        check("R1 err", W'(err_o), '0);
        rst_n = 1'b1;
        @(negedge clk);
        access(0, 0, '0, 2'd3, '0, rd);
        check("R1 mask0 zero", rd, '0);

        // R4: raw sampled from pins
        m_raw = 64'h0000_0000_0000_0001;
        dev_req_i = m_raw;
        idle(2);
        access(0, 2*NCPU, '0, 2'd3, m_raw, rd);
        check("R4 raw read", rd, m_raw);

        // R5: latency of interrupt after routing mask write
        access(1, 0, 64'h1, 2'd3, m_raw, rd);
        m_mask[0] = 64'h1;
        check("R2 write no err", W'(last_err), '0);
        check("R5 irq0 edge+0", W'(irq_o[0]), '0);
        @(negedge clk);
        check("R5 irq0 edge+1", W'(irq_o[0]), '0);
        @(negedge clk);
        check("R5 irq0 edge+2", W'(irq_o[0]), W'(1));
        check("R11 other cpus quiet", W'(irq_o[NCPU-1:1]), '0);
        access(0, NCPU, '0, 2'd3, m_raw, rd);
        check("R3 routed0", rd, exp_routed(0));
        access(0, 0, '0, 2'd3, m_raw, rd);
        check("R2 mask0 readback", rd, 64'h1);

        // R6: removing routed bits drops the interrupt
        m_raw = 64'h3;
        access(1, 0, 64'h3, 2'd3, m_raw, rd);
        m_mask[0] = 64'h3;
        idle(3);
        access(1, 0, 64'h2, 2'd3, m_raw, rd);
        m_mask[0] = 64'h2;
        idle(3);
        check("R6 one bit left keeps irq", W'(irq_o[0]), W'(1));
        access(1, 0, 64'h0, 2'd3, m_raw, rd);
        m_mask[0] = '0;
        @(negedge clk);
        check("R6 irq0 still high edge+1", W'(irq_o[0]), W'(1));
        @(negedge clk);
        check("R6 irq0 dropped", W'(irq_o[0]), '0);

        // R11: mask on cpu2 leaves cpu1 alone
        access(1, 2, 64'h1, 2'd3, m_raw, rd);
        m_mask[2] = 64'h1;
        idle(3);
        check("R11 irq vector", W'(irq_o), W'(exp_irq()));

        // R7: narrow accesses
        for (int s = 0; s < 3; s++) begin
            access(1, 1, {W{1'b1}}, 2'(s), m_raw, rd);
            check("R7 narrow write err", W'(last_err), W'(1));
            access(0, 2, '0, 2'(s), m_raw, rd);
            check("R7 narrow read err", W'(last_err), W'(1));
            check("R7 narrow read zero", rd, '0);
        end
        access(0, 1, '0, 2'd3, m_raw, rd);
        check("R7 mask1 untouched", rd, '0);

        // R8: writes to read-only registers
        access(1, NCPU + 2, {W{1'b1}}, 2'd3, m_raw, rd);
        check("R8 routed write err", W'(last_err), W'(1));
        access(1, 2*NCPU, {W{1'b1}}, 2'd3, m_raw, rd);
        check("R8 raw write err", W'(last_err), W'(1));
        access(0, NCPU + 2, '0, 2'd3, m_raw, rd);
        check("R8 routed2 unchanged", rd, exp_routed(2));
        access(0, 2*NCPU, '0, 2'd3, m_raw, rd);
        check("R8 raw unchanged", rd, m_raw);
        check("R8 irq unchanged", W'(irq_o), W'(exp_irq()));

        // R9: unmapped indices
        access(0, 2*NCPU + 1, '0, 2'd3, m_raw, rd);
        check("R9 unmapped err", W'(last_err), W'(1));
        check("R9 unmapped zero", rd, '0);
        access(0, 63, '0, 2'd3, m_raw, rd);
        check("R9 top index zero", rd, '0);
        @(negedge clk);
        check("R9 err one cycle", W'(err_o), '0);
        check("R10 no rsp when idle", W'(rsp_valid_o), '0);

        // Random: mask write and request change in the same cycle
        for (int i = 0; i < 60; i++) begin
            int c;
            logic [W-1:0] mk;
            c = int'($urandom_range(NCPU - 1, 0));
            mk = {$urandom(), $urandom()} & {$urandom(), $urandom()};
            if (i % 7 == 0) mk = '0;
            m_raw = {$urandom(), $urandom()} & {$urandom(), $urandom()} &
                    {$urandom(), $urandom()};
            if (i % 5 == 0) m_raw = '0;
            access(1, c, mk, 2'd3, m_raw, rd);
            m_mask[c] = mk;
            idle(3);
            check("R5 R11 random irq", W'(irq_o), W'(exp_irq()));
            access(0, NCPU + c, '0, 2'd3, m_raw, rd);
            check("R3 random routed", rd, exp_routed(c));
            access(0, c, '0, 2'd3, m_raw, rd);
            check("R2 random mask", rd, mk);
            access(0, 2*NCPU, '0, 2'd3, m_raw, rd);
            check("R4 random raw", rd, m_raw);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule